// File: doc/BRIEF.md
# Dual Falling-Edge Event Counter

This peripheral holds two independent up-counters, each advanced by high-to-low transitions on its own external pulse input. Each input is brought into the system clock domain through a two-flop synchronizer, and then a single-cycle falling-edge strobe is derived from it. Counting for each channel runs only while that channel's enable bit is set. When the enable is cleared, the count freezes at its current value.

A single 8-bit control/status byte packs three bits per channel: count enable, overflow-interrupt enable and a sticky overflow flag. When a counter wraps from all ones to zero with its interrupt enable set, its flag is set. Software may write a flag to 1 or to 0, and hardware only ever sets it. Each flag gated by its interrupt enable drives one shared interrupt line. Software can load each counter a byte at a time to set the number of events before the next overflow, and can read it back the same way.

One quirk is kept on purpose. If a counter reached zero by hardware (reset or wrap) and software then loads all ones, the next counted edge wraps to zero without raising the flag.

Top module: `evt_cnt_pair`

## Requirements
- R1: While a channel's enable is 1, each falling edge on its pulse input raises that channel's count by exactly one, and the other channel's count is unaffected.
- R2: While a channel's enable is 0, falling edges on its input leave its count unchanged. Counting resumes from the held value when the enable is set again.
- R3: Offset 0 is the control byte: bit7 enable 1, bit6 interrupt enable 1, bit4 flag 1, bit3 enable 2, bit2 interrupt enable 2, bit0 flag 2. Bits 5 and 1 always read 0.
- R4: A counted edge that takes a count from FFFFH to 0000H with that channel's interrupt enable at 1 sets that channel's flag.
- R5: A wrap with the interrupt enable at 0 still brings the count to 0000H but leaves the flag at 0.
- R6: Writing the control byte loads each flag from its bit (1 sets, 0 clears). Between writes, a set flag stays set.
- R7: irq_o is 1 exactly when (flag 1 AND interrupt enable 1) OR (flag 2 AND interrupt enable 2).
- R8: After reset, both counts read 0000H, the control byte reads 00H and irq_o is 0.
- R9: Offsets 1/2 are counter 1 low/high bytes and offsets 3/4 are counter 2 low/high bytes. A byte write changes only that byte, and counting continues from the loaded value.
- R10: Reads of offsets 5 to 7 return 00H.
- R11: The suppression quirk applies in this case: the count holds 0000H reached by reset or wrap, and software then loads FFFFH (the intermediate 00FFH or FF00H is allowed). The next counted edge wraps the count to 0000H without setting the flag. Any other load clears this state, and so does any counted edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one byte per cycle |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| pulse_i | input | 2 | Pulse inputs: bit 0 counter 1, bit 1 counter 2 |
| irq_o | output | 1 | Combined overflow interrupt request |

## Verification
The suppression quirk is the hardest case to reach. It depends on how the counter got to zero and on a two-byte load, not on the count value. The stimulus reaches it from reset, and a second time from a real hardware wrap after clearing the flag. It also runs a contrasting load (FFFEH followed by two edges) that must flag. Overflow cases are reached by preloading near all ones through the byte registers rather than by driving 65536 pulses.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  localparam int unsigned NUM_CH     = 2;
  localparam int unsigned CH_FIELD_W = 4;
  localparam int unsigned EN_BIT     = 3;
  localparam int unsigned IE_BIT     = 2;
  localparam int unsigned FLG_BIT    = 0;
  localparam int unsigned RSV_BIT    = 1;

  typedef struct packed {
    logic en;
    logic ie;
    logic flag;
  } ch_ctrl_t;
endpackage

// File: rtl/evt_fall_det.sv
module evt_fall_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic fall_o
);
  // sh_q[SYNC_STAGES-1] is the synchronized level, sh_q[SYNC_STAGES] its delayed copy
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], pulse_i};
  end

  assign fall_o = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned BYTES = CNT_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [BYTES-1:0] wr_be_i,
  input  logic [7:0]       wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_req_o
);
  logic [CNT_W-1:0] cnt_q, cnt_wr;
  logic             hw_zero_q, supp_q;
  logic             wr_any, step, wrap, bytes_ok;

  always_comb begin
    cnt_wr   = cnt_q;
    bytes_ok = 1'b1;
    for (int b = 0; b < int'(BYTES); b++) begin
      if (wr_be_i[b]) cnt_wr[b*8 +: 8] = wdata_i;
    end
    for (int b = 0; b < int'(BYTES); b++) begin
      if (cnt_wr[b*8 +: 8] != 8'h00 && cnt_wr[b*8 +: 8] != 8'hff) bytes_ok = 1'b0;
    end
  end

  assign wr_any = |wr_be_i;
  assign step   = tick_i & en_i & ~wr_any;  // a write wins over a coincident edge
  assign wrap   = step & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      hw_zero_q <= 1'b1;
      supp_q    <= 1'b0;
    end else if (wr_any) begin
      cnt_q <= cnt_wr;
      if (&cnt_wr) begin
        supp_q    <= hw_zero_q;
        hw_zero_q <= 1'b0;
      end else begin
        supp_q    <= 1'b0;
        // partial all-ones loads on the way to FFFFH keep the marker
        hw_zero_q <= hw_zero_q & bytes_ok & (|cnt_wr);
      end
    end else if (step) begin
      cnt_q     <= cnt_q + CNT_W'(1);
      supp_q    <= 1'b0;
      hw_zero_q <= wrap;
    end
  end

  assign cnt_o      = cnt_q;
  assign flag_req_o = wrap & ~supp_q;
endmodule

// File: rtl/evt_ctrl_reg.sv
module evt_ctrl_reg
  import evt_cnt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic [NUM_CH-1:0] hw_set_i,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] ie_o,
  output logic [NUM_CH-1:0] flag_o,
  output logic [7:0]        rdata_o
);
  ch_ctrl_t [NUM_CH-1:0] ctl_q;
  logic     [NUM_CH-1:0] unused_wbits;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    // counter 1 sits in the upper nibble
    localparam int unsigned BASE = (NUM_CH - 1 - k) * CH_FIELD_W;
    logic set_hw;
    assign set_hw          = hw_set_i[k] & ctl_q[k].ie;
    assign unused_wbits[k] = wdata_i[BASE + RSV_BIT];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctl_q[k] <= '0;
      end else if (wr_i) begin
        ctl_q[k].en   <= wdata_i[BASE + EN_BIT];
        ctl_q[k].ie   <= wdata_i[BASE + IE_BIT];
        ctl_q[k].flag <= wdata_i[BASE + FLG_BIT] | set_hw;
      end else if (set_hw) begin
        ctl_q[k].flag <= 1'b1;
      end
    end

    assign en_o[k]   = ctl_q[k].en;
    assign ie_o[k]   = ctl_q[k].ie;
    assign flag_o[k] = ctl_q[k].flag;
    assign rdata_o[BASE +: CH_FIELD_W] = {ctl_q[k].en, ctl_q[k].ie, 1'b0, ctl_q[k].flag};
  end
endmodule

// File: rtl/evt_cnt_pair.sv
module evt_cnt_pair
  import evt_cnt_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  output logic [7:0]        rdata_o,
  input  logic [NUM_CH-1:0] pulse_i,
  output logic              irq_o
);
  localparam int unsigned BYTES     = CNT_W / 8;
  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned CNT_BASE  = 1;

  logic [NUM_CH-1:0]            en_q, ie_q, flag_q, fall, flag_req, cnt_wr;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt;
  logic [7:0]                   ctrl_rd;
  logic                         ctrl_wr;

  assign ctrl_wr = we_i && (addr_i == ADDR_W'(CTRL_ADDR));

  evt_ctrl_reg u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (ctrl_wr),
    .wdata_i  (wdata_i),
    .hw_set_i (flag_req),
    .en_o     (en_q),
    .ie_o     (ie_q),
    .flag_o   (flag_q),
    .rdata_o  (ctrl_rd)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic [BYTES-1:0] be;
    for (genvar b = 0; b < BYTES; b++) begin : g_be
      assign be[b] = we_i && (addr_i == ADDR_W'(CNT_BASE + k*BYTES + b));
    end
    assign cnt_wr[k] = |be;

    evt_fall_det #(.SYNC_STAGES(SYNC_STAGES)) u_fall (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pulse_i (pulse_i[k]),
      .fall_o  (fall[k])
    );

    evt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (fall[k]),
      .en_i       (en_q[k]),
      .wr_be_i    (be),
      .wdata_i    (wdata_i),
      .cnt_o      (cnt[k]),
      .flag_req_o (flag_req[k])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CTRL_ADDR)) rdata_o = ctrl_rd;
    for (int k = 0; k < int'(NUM_CH); k++) begin
      for (int b = 0; b < int'(BYTES); b++) begin
        if (addr_i == ADDR_W'(int'(CNT_BASE) + k*int'(BYTES) + b)) rdata_o = cnt[k][b*8 +: 8];
      end
    end
  end

  assign irq_o = |(flag_q & ie_q);
endmodule

// File: rtl/evt_cnt_pair_chk.sv
module evt_cnt_pair_chk
  import evt_cnt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [ADDR_W-1:0]            addr_i,
  input logic [7:0]                   rdata_o,
  input logic                         irq_o,
  input logic                         ctrl_wr,
  input logic [NUM_CH-1:0]            en_q,
  input logic [NUM_CH-1:0]            ie_q,
  input logic [NUM_CH-1:0]            flag_q,
  input logic [NUM_CH-1:0]            cnt_wr,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt
);
  localparam int unsigned LAST_ADDR = NUM_CH * (CNT_W / 8);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cnt_wr[k] |=> (cnt[k] == $past(cnt[k])) || (cnt[k] == CNT_W'($past(cnt[k]) + 1'b1)));

    assert_hold_when_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_q[k] && !cnt_wr[k]) |=> $stable(cnt[k]));

    assert_no_flag_without_ie_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ie_q[k] && !ctrl_wr) |=> !$rose(flag_q[k]));

    assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[k] && !ctrl_wr) |=> flag_q[k]);
  end

  assert_irq_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(flag_q & ie_q));

  always_comb begin
    if (rst_ni && (int'(addr_i) > int'(LAST_ADDR)))
      assert_unused_zero_R10: assert (rdata_o == 8'h00);
  end
endmodule

bind evt_cnt_pair evt_cnt_pair_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .ctrl_wr (ctrl_wr),
  .en_q    (en_q),
  .ie_q    (ie_q),
  .flag_q  (flag_q),
  .cnt_wr  (cnt_wr),
  .cnt     (cnt)
);

// File: tb/evt_cnt_pair_tb_top.sv
`timescale 1ns/1ps
module evt_cnt_pair_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic [1:0] pulse = 2'b11;
  logic       irq;
  int         n_run = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  evt_cnt_pair dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .addr_i  (addr),
    .wdata_i (wdata),
    .we_i    (we),
    .rdata_o (rdata),
    .pulse_i (pulse),
    .irq_o   (irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    we = 1'b0;
    pulse = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_ch(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pulse[ch] = 1'b0;
      repeat (4) @(negedge clk);
      pulse[ch] = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic t_reset_R8();
    logic [7:0] d;
    do_reset();
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check("R8 reset value", d, 0);
    end
    check("R8 irq after reset", irq, 0);
  endtask

  task automatic t_count_R1();
    logic [7:0] d;
    do_reset();
    wr(0, 8'h80);
    pulse_ch(0, 3);
    rd(1, d); check("R1 counter1 low", d, 3);
    rd(2, d); check("R1 counter1 high", d, 0);
    rd(3, d); check("R1 counter2 untouched", d, 0);
    wr(0, 8'h88);
    pulse_ch(1, 2);
    rd(3, d); check("R1 counter2 low", d, 2);
    rd(1, d); check("R1 counter1 unchanged by ch2", d, 3);
  endtask

  task automatic t_hold_R2();
    logic [7:0] d;
    do_reset();
    wr(0, 8'h80);
    pulse_ch(0, 2);
    wr(0, 8'h00);
    pulse_ch(0, 3);
    rd(1, d); check("R2 held while disabled", d, 2);
    wr(0, 8'h80);
    pulse_ch(0, 1);
    rd(1, d); check("R2 resumes from held value", d, 3);
  endtask

  task automatic t_layout_R3();
    logic [7:0] d;
    do_reset();
    wr(0, 8'hff); rd(0, d); check("R3 reserved bits read 0", d, 8'hdd);
    wr(0, 8'h44); rd(0, d); check("R3 ie bits position", d, 8'h44);
    wr(0, 8'h88); rd(0, d); check("R3 enable bits position", d, 8'h88);
  endtask

  task automatic t_overflow_R4();
    logic [7:0] d;
    do_reset();
    wr(0, 8'h0c);
    wr(3, 8'hfe); wr(4, 8'hff);
    pulse_ch(1, 1);
    rd(0, d); check("R4 no flag before wrap", d, 8'h0c);
    pulse_ch(1, 1);
    rd(3, d); check("R4 wrapped low", d, 0);
    rd(4, d); check("R4 wrapped high", d, 0);
    rd(0, d); check("R4 flag2 set", d, 8'h0d);
    check("R4 irq raised", irq, 1);
  endtask

  task automatic t_no_ie_R5();
    logic [7:0] d;
    do_reset();
    wr(0, 8'h80);
    wr(1, 8'hfe); wr(2, 8'hff);
    pulse_ch(0, 2);
    rd(2, d); check("R5 wrapped high", d, 0);
    rd(0, d); check("R5 flag stays clear", d, 8'h80);
    check("R5 irq low", irq, 0);
  endtask

  task automatic t_sw_flag_R6_R7();
    logic [7:0] d;
    do_reset();
    wr(0, 8'h10); rd(0, d); check("R6 sw set flag1", d, 8'h10);
    check("R7 flag without ie", irq, 0);
    wr(0, 8'h50); check("R7 flag1 with ie1", irq, 1);
    wr(0, 8'h40); rd(0, d); check("R6 sw clear flag1", d, 8'h40);
    check("R7 irq drops", irq, 0);
    wr(0, 8'h45); check("R7 flag2 with ie2", irq, 1);
    wr(0, 8'h51); check("R7 flag1 path, ie2 off", irq, 1);
    wr(0, 8'h11); check("R7 both ie off", irq, 0);
    rd(0, d); check("R6 both flags held", d, 8'h11);
  endtask

  task automatic t_bytes_R9_R10();
    logic [7:0] d;
    do_reset();
    wr(1, 8'h34); wr(2, 8'h12); wr(3, 8'hcd); wr(4, 8'hab);
    rd(1, d); check("R9 c1 low", d, 8'h34);
    rd(2, d); check("R9 c1 high", d, 8'h12);
    rd(3, d); check("R9 c2 low", d, 8'hcd);
    rd(4, d); check("R9 c2 high", d, 8'hab);
    wr(3, 8'h77);
    rd(4, d); check("R9 high kept on low write", d, 8'hab);
    wr(0, 8'h80);
    pulse_ch(0, 1);
    rd(1, d); check("R9 counts from load", d, 8'h35);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), d);
      check("R10 unused offset", d, 0);
    end
  endtask

  task automatic t_quirk_R11();
    logic [7:0] d;
    do_reset();
    wr(0, 8'hc0);
    wr(1, 8'hff); wr(2, 8'hff);
    pulse_ch(0, 1);
    rd(1, d); check("R11 wrap after reset load", d, 0);
    rd(0, d); check("R11 flag suppressed after reset", d, 8'hc0);
    check("R11 irq low", irq, 0);
    wr(1, 8'hfe); wr(2, 8'hff);
    pulse_ch(0, 2);
    rd(0, d); check("R11 normal load flags", d, 8'hd0);
    wr(0, 8'hc0);
    wr(1, 8'hff); wr(2, 8'hff);
    pulse_ch(0, 1);
    rd(2, d); check("R11 wrap after hw zero load", d, 0);
    rd(0, d); check("R11 flag suppressed after wrap", d, 8'hc0);
    pulse_ch(0, 1);
    rd(1, d); check("R11 counting continues", d, 1);
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset_R8();
    t_count_R1();
    t_hold_R2();
    t_layout_R3();
    t_overflow_R4();
    t_no_ie_R5();
    t_sw_flag_R6_R7();
    t_bytes_R9_R10();
    t_quirk_R11();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule